// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory whose command interface never needs an idle cycle between a read and a write. Every enabled clock edge can accept one operation, in any mix of reads and writes, so the data bus can carry a word on every cycle of continuous traffic. Command, address, byte enables and chip selects are registered on the clock edge. Read data then flows from the array to the output pins without a second output register, so it appears in the cycle right after the command edge.

A write takes its data one enabled edge after its command. In that cycle the bus would otherwise be turning around, so the bus turnaround is hidden. The captured address of a write waits in the access register until its data arrives. The array is updated on that same edge, so a read issued directly behind the write sees the new word.

Each burst runs four beats, and a mode bit picks linear or interleaved order. Three chip enables allow depth expansion. A clock enable freezes the whole block. An asynchronous output enable gates the read data, and a sleep input blocks new accesses.

Top module: `sram_flow`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read command accepted on an enabled edge presents the stored word of its address on `rdata` with `rvalid`=1 for the whole cycle that follows that edge, provided `out_en` is 1.
- R3: The data of a write is taken from `wdata` on the next enabled edge after its command edge. Reads and writes may follow each other on consecutive edges in any order, and a read of the same address right after a write returns the written data.
- R4: Bit `byte_we[i]` enables lane i, which is bits `[8*i+7:8*i]` of the word. On a write only the enabled lanes change and the others keep their old value. The enables are sampled with the command, or with the beat for a burst.
- R5: On an edge with `clk_en`=0, nothing changes. No command is taken, no write data is stored, and `rvalid`/`rdata` keep their values.
- R6: A new command is accepted only when `ce_a`=1, `ce_b_n`=0 and `ce_c`=1. Otherwise the edge is a deselect: no access happens and `rvalid` is 0 in the following cycle.
- R7: With `cmd_adv`=1 while a burst is live, the next beat uses the loaded address. Its two low bits become (start + k) mod 4 for beat k when the loaded mode bit `burst_ilv` was 0. The upper bits never change, and the sequence wraps after four beats.
- R8: When `burst_ilv` was 1 at the load edge, the beat k low bits are start XOR k. The mode bit is sampled only at the load edge.
- R9: A continuing beat repeats the read/write type of the load command and ignores `cmd_we`, `addr` and the chip enables. `cmd_adv`=1 with no live burst is an idle cycle and ends nothing new.
- R10: `rvalid` is the registered read flag ANDed with `out_en` without a clock. While `rvalid` is 0, `rdata` is all zeros.
- R11: On an enabled edge with `sleep`=1, no new command and no burst beat is taken, and the live burst ends. The data of a write accepted on the edge before is still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| sleep | input | 1 | Power-down request; blocks accesses |
| ce_a | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| cmd_we | input | 1 | 1 = write command, 0 = read command |
| cmd_adv | input | 1 | 1 = continue the live burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address of a new command |
| byte_we | input | DATA_W/LANE_W | Per-lane write enables |
| wdata | input | DATA_W | Write data, one enabled edge after the command |
| out_en | input | 1 | Asynchronous output enable |
| rvalid | output | 1 | Read data valid / output drive enable |
| rdata | output | DATA_W | Read data, zero when not valid |

## Verification
The memory is first filled by an unbroken run of writes. After that come alternating write and read pairs to one address, which separate a correct hidden-turnaround write from one that stores the data one edge late or early. Partial byte masks and frozen edges with a changing `wdata` show whether the lanes and the clock enable really guard the array. Each chip enable is taken wrong in turn to tell a deselect from an access. Linear and interleaved bursts from odd start addresses, with the mode input flipped in the middle of a burst, tell the two orders apart and test where the mode is sampled. Sleep edges and output enable toggles in the middle of a cycle cover the blocking and asynchronous gating paths.

// File: rtl/sram_flow_pkg.sv
package sram_flow_pkg;
  localparam int BEAT_W   = 2;
  localparam int BURST_LEN = 1 << BEAT_W;

  // low address bits of a burst beat
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              ilv
  );
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

  function automatic logic chip_selected(input logic a, input logic b_n, input logic c);
    return a & ~b_n & c;
  endfunction
endpackage

// File: rtl/sram_flow_ctrl.sv
module sram_flow_ctrl
  import sram_flow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              ce_a,
  input  logic              ce_b_n,
  input  logic              ce_c,
  input  logic              cmd_we,
  input  logic              cmd_adv,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  output logic              acc_q,
  output logic              acc_we_q,
  output logic [ADDR_W-1:0] acc_addr_q,
  output logic [LANES-1:0]  acc_be_q
);
  logic              live_q;
  logic              ilv_q;
  logic              bwe_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  logic              sel_now;
  logic              new_cmd;
  logic              adv_go;
  logic [BEAT_W-1:0] beat_nx;
  logic [ADDR_W-1:0] adv_addr;

  assign sel_now  = chip_selected(ce_a, ce_b_n, ce_c);
  assign new_cmd  = !sleep && !cmd_adv && sel_now;
  assign adv_go   = !sleep && cmd_adv && live_q;
  assign beat_nx  = beat_q + 1'b1;
  assign adv_addr = {base_q[ADDR_W-1:BEAT_W], beat_offset(base_q[BEAT_W-1:0], beat_nx, ilv_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= 1'b0;
      ilv_q      <= 1'b0;
      bwe_q      <= 1'b0;
      base_q     <= '0;
      beat_q     <= '0;
      acc_q      <= 1'b0;
      acc_we_q   <= 1'b0;
      acc_addr_q <= '0;
      acc_be_q   <= '0;
    end else if (clk_en) begin
      if (new_cmd) begin
        live_q     <= 1'b1;
        ilv_q      <= burst_ilv;
        bwe_q      <= cmd_we;
        base_q     <= addr;
        beat_q     <= '0;
        acc_q      <= 1'b1;
        acc_we_q   <= cmd_we;
        acc_addr_q <= addr;
        acc_be_q   <= byte_we;
      end else if (adv_go) begin
        beat_q     <= beat_nx;
        acc_q      <= 1'b1;
        acc_we_q   <= bwe_q;
        acc_addr_q <= adv_addr;
        acc_be_q   <= byte_we;
      end else begin
        live_q     <= 1'b0;
        acc_q      <= 1'b0;
      end
    end
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !cmd_adv && !sel_now) |=> !acc_q); // R6
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> !acc_q); // R11
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(acc_q) && $stable(acc_addr_q) && $stable(acc_we_q))); // R5
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_go && !ilv_q) |=> (acc_addr_q[1:0] == $past(acc_addr_q[1:0]) + 2'd1)); // R7
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_go && ilv_q) |=> (acc_addr_q[ADDR_W-1:2] == $past(acc_addr_q[ADDR_W-1:2]))); // R8
  AST_BURST_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_go && acc_q) |=> (acc_we_q == $past(acc_we_q))); // R9
endmodule

// File: rtl/sram_flow_array.sv
module sram_flow_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged;

  assign old_word = mem[wr_addr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = wr_be[g] ? wr_data[g*LANE_W +: LANE_W]
                                                 : old_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (clk_en && wr_go) mem[wr_addr] <= merged;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/sram_flow_out.sv
module sram_flow_out #(
  parameter int DATA_W = 32
) (
  input  logic              acc_q,
  input  logic              acc_we_q,
  input  logic              out_en,
  input  logic [DATA_W-1:0] word,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  assign rvalid = acc_q && !acc_we_q && out_en;
  assign rdata  = rvalid ? word : '0;
endmodule

// File: rtl/sram_flow.sv
module sram_flow #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              ce_a,
  input  logic              ce_b_n,
  input  logic              ce_c,
  input  logic              cmd_we,
  input  logic              cmd_adv,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_en,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic              acc_q;
  logic              acc_we_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic [LANES-1:0]  acc_be_q;
  logic [DATA_W-1:0] arr_word;
  logic              wr_go;

  assign wr_go = acc_q && acc_we_q;

  sram_flow_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .ce_a(ce_a), .ce_b_n(ce_b_n), .ce_c(ce_c),
    .cmd_we(cmd_we), .cmd_adv(cmd_adv), .burst_ilv(burst_ilv),
    .addr(addr), .byte_we(byte_we),
    .acc_q(acc_q), .acc_we_q(acc_we_q), .acc_addr_q(acc_addr_q), .acc_be_q(acc_be_q)
  );

  sram_flow_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk(clk), .clk_en(clk_en), .wr_go(wr_go), .wr_addr(acc_addr_q),
    .wr_be(acc_be_q), .wr_data(wdata), .rd_addr(acc_addr_q), .rd_word(arr_word)
  );

  sram_flow_out #(.DATA_W(DATA_W)) u_out (
    .acc_q(acc_q), .acc_we_q(acc_we_q), .out_en(out_en), .word(arr_word),
    .rvalid(rvalid), .rdata(rdata)
  );

  AST_NO_DATA_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !rvalid); // R10
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0)); // R10
endmodule

// File: tb/sram_flow_tb_top.sv
`timescale 1ns/1ps
module sram_flow_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NL = 4;

  logic clk = 0, rst_n = 0, clk_en = 1, sleep = 0;
  logic ce_a = 1, ce_b_n = 0, ce_c = 1;
  logic cmd_we = 0, cmd_adv = 0, burst_ilv = 0, out_en = 1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byte_we = '1;
  logic [DW-1:0] wdata = '0;
  logic rvalid;
  logic [DW-1:0] rdata;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  logic [31:0] prng = 32'h1234_5678;

  always #10 clk = ~clk;

  sram_flow dut_i (.*);

  // behavioural reference
  logic [DW-1:0] m_mem [256];
  bit m_wpend, m_rd, m_live, m_ilv, m_bwe;
  int m_waddr, m_raddr, m_base, m_cnt;
  logic [NL-1:0] m_wbe;

  task automatic m_access(input int a, input bit we);
    if (we) begin m_wpend = 1; m_waddr = a; m_wbe = byte_we; end
    else begin m_rd = 1; m_raddr = a; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wpend = 0; m_rd = 0; m_live = 0;
    end else if (clk_en) begin
      if (m_wpend)
        for (int i = 0; i < NL; i++)
          if (m_wbe[i]) m_mem[m_waddr][i*8 +: 8] = wdata[i*8 +: 8];
      m_wpend = 0; m_rd = 0;
      if (!sleep && cmd_adv && m_live) begin
        int lo;
        m_cnt = (m_cnt + 1) % 4;
        lo = m_ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        m_access((m_base / 4) * 4 + lo, m_bwe);
      end else if (!sleep && !cmd_adv && ce_a && !ce_b_n && ce_c) begin
        m_live = 1; m_base = int'(addr); m_cnt = 0; m_ilv = burst_ilv; m_bwe = cmd_we;
        m_access(int'(addr), cmd_we);
      end else m_live = 0;
    end
  end

  task automatic compare();
    logic ev; logic [DW-1:0] ed;
    ev = m_rd && out_en;
    ed = ev ? m_mem[m_raddr] : '0;
    n_checks++;
    if (rvalid !== ev || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h at %0t",
               cur_req, rvalid, rdata, ev, ed, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic op(input bit we, input bit adv, input int a, input logic [NL-1:0] be);
    cmd_we = we; cmd_adv = adv; addr = AW'(a); byte_we = be;
    prng = prng * 32'd1103515245 + 32'd12345;
    wdata = prng;
    tick();
  endtask

  task automatic idle();
    ce_a = 0; op(0, 0, 0, '1); ce_a = 1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    ce_a = 0;
    repeat (2) begin @(negedge clk); compare(); end
    rst_n = 1;
    tick();
    ce_a = 1;

    // R3 back-to-back writes fill memory
    cur_req = "R3";
    for (int i = 0; i < 256; i++) op(1, 0, i, '1);
    op(0, 0, 0, '1);
    // R3 alternating write/read same address and others
    for (int i = 0; i < 20; i++) begin op(1, 0, i * 7, '1); op(0, 0, i * 7, '1); end
    for (int i = 0; i < 10; i++) begin op(0, 0, i, '1); op(1, 0, i + 1, '1); end
    // R2 reads of varied addresses
    cur_req = "R2";
    for (int i = 0; i < 16; i++) op(0, 0, (i * 37) % 256, '1);

    // R4 byte lanes
    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin op(1, 0, 40, NL'(i)); op(0, 0, 40, '1); end
    op(1, 0, 41, 4'b0000); op(0, 0, 41, '1);

    // R5 clock enable freeze
    cur_req = "R5";
    op(0, 0, 50, '1);
    clk_en = 0;
    for (int i = 0; i < 4; i++) op(1, 0, 51, '1);
    clk_en = 1;
    op(1, 0, 52, '1);
    clk_en = 0;
    for (int i = 0; i < 3; i++) op(0, 0, 53, '1);
    clk_en = 1;
    op(0, 0, 52, '1);

    // R6 chip enables
    cur_req = "R6";
    for (int k = 0; k < 3; k++) begin
      ce_a = (k != 0); ce_b_n = (k == 1); ce_c = (k != 2);
      op(1, 0, 60 + k, '1);
      op(0, 0, 60 + k, '1);
      ce_a = 1; ce_b_n = 0; ce_c = 1;
      op(0, 0, 60 + k, '1);
    end

    // R7 linear bursts, read and write, with wrap
    cur_req = "R7";
    burst_ilv = 0;
    op(0, 0, 8'h22, '1);
    for (int i = 0; i < 6; i++) op(0, 1, 0, '1);
    op(1, 0, 8'h31, '1);
    for (int i = 0; i < 3; i++) op(1, 1, 0, '1);
    op(0, 0, 8'h30, '1);
    for (int i = 0; i < 3; i++) op(0, 1, 0, '1);

    // R8 interleaved, mode flipped mid-burst
    cur_req = "R8";
    burst_ilv = 1;
    op(1, 0, 8'h47, 4'b1010);
    burst_ilv = 0;
    for (int i = 0; i < 3; i++) op(1, 1, 0, 4'b0101);
    burst_ilv = 1;
    op(0, 0, 8'h45, '1);
    burst_ilv = 0;
    for (int i = 0; i < 5; i++) op(0, 1, 0, '1);

    // R9 burst type kept, adv without burst is idle
    cur_req = "R9";
    op(0, 0, 8'h70, '1);
    op(1, 1, 8'h99, '1);
    op(1, 1, 8'h99, '1);
    idle();
    op(0, 1, 8'h70, '1);
    op(1, 1, 8'h70, '1);
    op(0, 0, 8'h71, '1);

    // R10 asynchronous output enable
    cur_req = "R10";
    op(0, 0, 8'h22, '1);
    out_en = 0; #2; compare();
    out_en = 1; #2; compare();
    out_en = 0;
    op(0, 0, 8'h23, '1);
    out_en = 1; #2; compare();

    // R11 sleep
    cur_req = "R11";
    op(1, 0, 8'h80, '1);
    sleep = 1;
    op(0, 0, 8'h80, '1);
    op(1, 0, 8'h81, '1);
    sleep = 0;
    op(0, 0, 8'h80, '1);
    op(0, 0, 8'h10, '1);
    sleep = 1;
    op(0, 1, 0, '1);
    sleep = 0;
    op(0, 1, 0, '1);
    op(0, 0, 8'h81, '1);
    idle();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule